// File: doc/BRIEF.md
# Shift Rotate Mask Unit

A combinational 64-bit execution unit that performs the shift and rotate family of a RISC integer pipeline. A decoded operation code selects one of five functions: left shift, right shift (logical or arithmetic), word rotate with mask and insert, doubleword rotate with clear and insert, and a sign-extend-word-then-shift-left. The same cycle that presents the operands returns a 64-bit result, a valid flag, and two carry bits.

The caller supplies the source value `rs`, an insert value `ra`, the low seven bits of the amount operand `rb`, and the two mask fields taken from the instruction. One barrel rotator serves both rotate functions. A mask generator numbers bits from the most significant end and wraps around when the start position lies past the end position. The operation code and a small routing tag pass through to the outputs unchanged, so that a surrounding pipeline can steer the result back.

Top module: `srm_unit`

## Requirements
- R1: Left shift (code 1). In 32-bit mode the amount is rb[5:0], the result holds bits 31..0 of rs shifted left, and bits 63..32 are zero. In 64-bit mode the amount is rb[6:0], and an amount of 64 or more gives zero.
- R2: Right shift (code 2). In 32-bit mode the operand is rs[31:0], zero-extended when the signed flag is low and sign-extended when it is high, and the amount is rb[5:0]. In 64-bit mode the operand is all of rs and the amount is rb[6:0]. The vacated bits fill with zero (unsigned) or with the operand sign (signed).
- R3: A signed right shift sets the carry only when the extended operand is negative and at least one 1 bit leaves through the low end. Both carry outputs carry the same value.
- R4: Every other operation, including an unsigned right shift, drives both carry outputs to zero.
- R5: Word rotate (code 3). {rs[31:0], rs[31:0]} is rotated left by rb[4:0]. The mask runs from position mb[4:0]+32 to position me+32, and the result is (rot & mask) | (ra & ~mask).
- R6: Doubleword rotate (code 4). rs is rotated left by rb[5:0]. The mask start is {mb[0], mb[5:1]} and the mask end is 63 - rb[5:0]. The same insert formula applies.
- R7: Mask positions count from the most significant bit, so position p is bit 63-p. When start <= end, positions start..end are set. Otherwise the mask wraps and positions start..63 and 0..end are set.
- R8: Extend-shift (code 5). rs[31:0] is sign-extended to 64 bits and shifted left by rb[5:0], whatever the mode flag says.
- R9: Valid is high exactly for codes 1 to 5. Codes 0, 6 and 7 give valid low and a zero result.
- R10: The operation code and the routing tag appear unchanged at their outputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation code |
| word_mode_i | input | 1 | 32-bit mode flag |
| signed_i | input | 1 | Arithmetic right shift when high |
| rs_i | input | 64 | Value to shift or rotate |
| ra_i | input | 64 | Insert value for the rotates |
| rb_i | input | 7 | Low bits of the amount operand |
| mb_i | input | 6 | Mask-begin field |
| me_i | input | 5 | Mask-end field (word rotate) |
| tag_i | input | TAG_W | Routing tag |
| op_o | output | 3 | Operation code, passed through |
| tag_o | output | TAG_W | Routing tag, passed through |
| result_o | output | 64 | Result |
| valid_o | output | 1 | High for a recognised operation |
| ca_o | output | 1 | Carry |
| ca32_o | output | 1 | 32-bit carry, equal to ca_o |

## Verification
The embedded checks are immediate and evaluated inside combinational processes, so they assume the inputs have settled and hold steady while they are evaluated. They also assume only two-valued inputs. The stimulus changes the inputs just after a bench clock edge and reads the outputs half a period later, and it never drives unknown values. The input fields cover their full ranges, including wrapped masks, shift amounts past the operand width, negative operands and the undefined codes, so no assumption about input range is needed beyond the port widths.

// File: rtl/srm_pkg.sv
package srm_pkg;
    localparam int XLEN  = 64;
    localparam int HALF  = XLEN / 2;
    localparam int SH_W  = $clog2(XLEN);
    localparam int OP_W  = 3;

    typedef enum logic [OP_W-1:0] {
        SRM_NOP  = 3'd0,
        SRM_SHL  = 3'd1,
        SRM_SHR  = 3'd2,
        SRM_RLW  = 3'd3,
        SRM_RLD  = 3'd4,
        SRM_EXSL = 3'd5
    } srm_op_e;

    typedef struct packed {
        logic [XLEN-1:0] result;
        logic            valid;
        logic            ca;
    } srm_res_t;
endpackage

// File: rtl/srm_rotator.sv
module srm_rotator #(
    parameter int W = 64,
    localparam int AW = $clog2(W)
) (
    input  logic [W-1:0]  data_i,
    input  logic [AW-1:0] amt_i,
    output logic [W-1:0]  data_o
);
    logic [W-1:0] stage_d [AW+1];

    assign stage_d[0] = data_i;

    for (genvar s = 0; s < AW; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stage_d[s+1] = amt_i[s]
            ? {stage_d[s][W-1-STEP:0], stage_d[s][W-1:W-STEP]}
            : stage_d[s];
    end

    assign data_o = stage_d[AW];

    always_comb begin
        // R6
        rot_ones_chk: assert ($countones(data_o) == $countones(data_i));
    end
endmodule

// File: rtl/srm_mask.sv
module srm_mask #(
    parameter int W = 64,
    localparam int AW = $clog2(W)
) (
    input  logic [AW-1:0] start_i,
    input  logic [AW-1:0] end_i,
    output logic [W-1:0]  mask_o
);
    logic [W-1:0] from_start_d;
    logic [W-1:0] upto_end_d;

    always_comb begin
        from_start_d = {W{1'b1}} >> start_i;
        upto_end_d   = ~(({W{1'b1}} >> end_i) >> 1);
        if (start_i <= end_i) begin
            mask_o = from_start_d & upto_end_d;
        end else begin
            mask_o = from_start_d | upto_end_d;
        end
    end

    always_comb begin
        // R7
        if (start_i <= end_i) begin
            mask_width_chk: assert ($countones(mask_o) ==
                                    int'(end_i) - int'(start_i) + 1);
        end else begin
            mask_wrap_chk: assert ($countones(mask_o) ==
                                   W + 1 - int'(start_i) + int'(end_i));
        end
    end
endmodule

// File: rtl/srm_shifter.sv
module srm_shifter #(
    parameter int W = 64,
    localparam int HW = W / 2,
    localparam int AW = $clog2(W),
    localparam int EW = 2 * W
) (
    input  logic         word_mode_i,
    input  logic         signed_i,
    input  logic [W-1:0] rs_i,
    input  logic [AW:0]  rb_i,
    output logic [W-1:0] shl_o,
    output logic [W-1:0] shr_o,
    output logic         shr_ca_o,
    output logic [W-1:0] exsl_o
);
    logic [W-1:0]  shl_raw_d;
    logic [EW-1:0] ext_d;
    logic [EW-1:0] shr_raw_d;
    logic [EW-1:0] keep_d;
    logic [AW:0]   amt_d;
    logic          lost_d;
    logic [W-1:0]  sext_d;

    always_comb begin
        amt_d = word_mode_i ? {1'b0, rb_i[AW-1:0]} : rb_i;

        shl_raw_d = rs_i << amt_d;
        if (word_mode_i) begin
            shl_o = {{HW{1'b0}}, shl_raw_d[HW-1:0]};
        end else begin
            shl_o = shl_raw_d;
        end

        if (word_mode_i) begin
            ext_d = {{(EW-HW){signed_i & rs_i[HW-1]}}, rs_i[HW-1:0]};
        end else begin
            ext_d = {{(EW-W){signed_i & rs_i[W-1]}}, rs_i};
        end
        shr_raw_d = $unsigned($signed(ext_d) >>> amt_d);
        shr_o     = shr_raw_d[W-1:0];
        keep_d    = {EW{1'b1}} << amt_d;
        lost_d    = |(ext_d & ~keep_d);
        shr_ca_o  = signed_i & ext_d[EW-1] & lost_d;

        sext_d = {{HW{rs_i[HW-1]}}, rs_i[HW-1:0]};
        exsl_o = sext_d << rb_i[AW-1:0];
    end

    always_comb begin
        // R3
        if (shr_ca_o) begin
            shr_carry_sign_chk: assert (signed_i &&
                (word_mode_i ? rs_i[HW-1] : rs_i[W-1]));
        end
        // R2
        if (!signed_i && word_mode_i) begin
            shr_word_zext_chk: assert (shr_o[W-1:HW] == '0);
        end
    end
endmodule

// File: rtl/srm_unit.sv
module srm_unit
    import srm_pkg::*;
#(
    parameter int TAG_W = 2
) (
    input  logic [OP_W-1:0]  op_i,
    input  logic             word_mode_i,
    input  logic             signed_i,
    input  logic [XLEN-1:0]  rs_i,
    input  logic [XLEN-1:0]  ra_i,
    input  logic [SH_W:0]    rb_i,
    input  logic [SH_W-1:0]  mb_i,
    input  logic [SH_W-2:0]  me_i,
    input  logic [TAG_W-1:0] tag_i,
    output logic [OP_W-1:0]  op_o,
    output logic [TAG_W-1:0] tag_o,
    output logic [XLEN-1:0]  result_o,
    output logic             valid_o,
    output logic             ca_o,
    output logic             ca32_o
);
    srm_op_e         op_d;
    logic [XLEN-1:0] shl_d;
    logic [XLEN-1:0] shr_d;
    logic            shr_ca_d;
    logic [XLEN-1:0] exsl_d;
    logic [XLEN-1:0] rot_in_d;
    logic [SH_W-1:0] rot_amt_d;
    logic [XLEN-1:0] rot_d;
    logic [SH_W-1:0] mstart_d;
    logic [SH_W-1:0] mend_d;
    logic [XLEN-1:0] mask_d;
    logic [XLEN-1:0] insert_d;
    srm_res_t        res_d;

    assign op_d = srm_op_e'(op_i);

    srm_shifter #(.W(XLEN)) i_shifter (
        .word_mode_i (word_mode_i),
        .signed_i    (signed_i),
        .rs_i        (rs_i),
        .rb_i        (rb_i),
        .shl_o       (shl_d),
        .shr_o       (shr_d),
        .shr_ca_o    (shr_ca_d),
        .exsl_o      (exsl_d)
    );

    // one rotator and one mask generator serve both rotate operations
    always_comb begin
        if (op_d == SRM_RLW) begin
            rot_in_d  = {rs_i[HALF-1:0], rs_i[HALF-1:0]};
            rot_amt_d = {1'b0, rb_i[SH_W-2:0]};
            mstart_d  = {1'b1, mb_i[SH_W-2:0]};
            mend_d    = {1'b1, me_i};
        end else begin
            rot_in_d  = rs_i;
            rot_amt_d = rb_i[SH_W-1:0];
            mstart_d  = {mb_i[0], mb_i[SH_W-1:1]};
            mend_d    = SH_W'(XLEN - 1) - rb_i[SH_W-1:0];
        end
    end

    srm_rotator #(.W(XLEN)) i_rotator (
        .data_i (rot_in_d),
        .amt_i  (rot_amt_d),
        .data_o (rot_d)
    );

    srm_mask #(.W(XLEN)) i_mask (
        .start_i (mstart_d),
        .end_i   (mend_d),
        .mask_o  (mask_d)
    );

    assign insert_d = (rot_d & mask_d) | (ra_i & ~mask_d);

    always_comb begin
        res_d = '0;
        unique case (op_d)
            SRM_SHL: begin
                res_d.result = shl_d;
                res_d.valid  = 1'b1;
            end
            SRM_SHR: begin
                res_d.result = shr_d;
                res_d.valid  = 1'b1;
                res_d.ca     = shr_ca_d;
            end
            SRM_RLW, SRM_RLD: begin
                res_d.result = insert_d;
                res_d.valid  = 1'b1;
            end
            SRM_EXSL: begin
                res_d.result = exsl_d;
                res_d.valid  = 1'b1;
            end
            default: res_d = '0;
        endcase
    end

    assign result_o = res_d.result;
    assign valid_o  = res_d.valid;
    assign ca_o     = res_d.ca;
    assign ca32_o   = res_d.ca;
    assign op_o     = op_i;
    assign tag_o    = tag_i;

    always_comb begin
        // R9
        if (!valid_o) begin
            idle_zero_chk: assert (result_o == '0);
        end
        // R4
        if (ca_o) begin
            carry_source_chk: assert (op_i == SRM_SHR && signed_i);
        end
        // R1
        if (op_i == SRM_SHL && word_mode_i) begin
            shl_word_upper_chk: assert (result_o[XLEN-1:HALF] == '0);
        end
    end
endmodule

// File: tb/test_srm_unit.sv
module test_srm_unit;
    localparam int CLK_PERIOD = 10;
    localparam int TAG_W = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [2:0]       op_i = '0;
    logic             word_mode_i = 1'b0;
    logic             signed_i = 1'b0;
    logic [63:0]      rs_i = '0;
    logic [63:0]      ra_i = '0;
    logic [6:0]       rb_i = '0;
    logic [5:0]       mb_i = '0;
    logic [4:0]       me_i = '0;
    logic [TAG_W-1:0] tag_i = '0;
    logic [2:0]       op_o;
    logic [TAG_W-1:0] tag_o;
    logic [63:0]      result_o;
    logic             valid_o;
    logic             ca_o;
    logic             ca32_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    srm_unit #(.TAG_W(TAG_W)) i_srm_unit (
        .op_i(op_i), .word_mode_i(word_mode_i), .signed_i(signed_i),
        .rs_i(rs_i), .ra_i(ra_i), .rb_i(rb_i), .mb_i(mb_i), .me_i(me_i),
        .tag_i(tag_i), .op_o(op_o), .tag_o(tag_o), .result_o(result_o),
        .valid_o(valid_o), .ca_o(ca_o), .ca32_o(ca32_o)
    );

    function automatic logic [63:0] msb_mask(input int s, input int e);
        logic [63:0] m = '0;
        for (int p = 0; p < 64; p++) begin
            bit in_range = (s <= e) ? (p >= s && p <= e) : (p >= s || p <= e);
            m[63-p] = in_range;
        end
        return m;
    endfunction

    function automatic void model(input int op, input bit wm, input bit sg,
                                  input logic [63:0] rs, input logic [63:0] ra,
                                  input logic [6:0] rb, input logic [5:0] mb,
                                  input logic [4:0] me,
                                  output logic [63:0] res, output bit vld,
                                  output bit ca);
        res = '0; vld = 0; ca = 0;
        case (op)
            1: begin
                int amt = wm ? int'(rb[5:0]) : int'(rb);
                int w = wm ? 32 : 64;
                vld = 1;
                for (int k = 0; k < 64; k++)
                    res[k] = (k < w && k >= amt) ? rs[k-amt] : 1'b0;
            end
            2: begin
                int amt = wm ? int'(rb[5:0]) : int'(rb);
                int w = wm ? 32 : 64;
                bit sb = sg && rs[w-1];
                bit lost = 0;
                vld = 1;
                for (int k = 0; k < 64; k++) begin
                    int j = k + amt;
                    res[k] = (j < w) ? rs[j] : sb;
                end
                for (int j = 0; j < amt; j++)
                    if ((j < w) ? rs[j] : sb) lost = 1;
                ca = sb && lost;
            end
            3, 4: begin
                logic [63:0] src;
                logic [63:0] rot;
                logic [63:0] m;
                int a;
                if (op == 3) begin
                    src = {rs[31:0], rs[31:0]};
                    a = int'(rb[4:0]);
                    m = msb_mask(int'(mb[4:0]) + 32, int'(me) + 32);
                end else begin
                    src = rs;
                    a = int'(rb[5:0]);
                    m = msb_mask(int'({mb[0], mb[5:1]}), 63 - a);
                end
                for (int k = 0; k < 64; k++) rot[k] = src[(k - a + 64) % 64];
                res = (rot & m) | (ra & ~m);
                vld = 1;
            end
            5: begin
                int a = int'(rb[5:0]);
                vld = 1;
                for (int k = 0; k < 64; k++)
                    res[k] = (k >= a) ? ((k - a) < 32 ? rs[k-a] : rs[31]) : 1'b0;
            end
            default: ;
        endcase
    endfunction

    function automatic string req_of(input int op);
        case (op)
            1: return "R1";
            2: return "R2";
            3: return "R5";
            4: return "R6";
            5: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic apply(input int op, input bit wm, input bit sg,
                         input logic [63:0] rs, input logic [63:0] ra,
                         input logic [6:0] rb, input logic [5:0] mb,
                         input logic [4:0] me, input logic [TAG_W-1:0] tag);
        logic [63:0] e_res;
        bit e_vld;
        bit e_ca;
        @(posedge clk);
        op_i = op[2:0]; word_mode_i = wm; signed_i = sg;
        rs_i = rs; ra_i = ra; rb_i = rb; mb_i = mb; me_i = me; tag_i = tag;
        model(op, wm, sg, rs, ra, rb, mb, me, e_res, e_vld, e_ca);
        @(negedge clk);
        check(req_of(op), "result", result_o, e_res);
        check("R9", "valid", 64'(valid_o), 64'(e_vld));
        // R3 carry value and equality of both carry bits; R4 zero elsewhere
        check(e_ca ? "R3" : "R4", "ca", 64'(ca_o), 64'(e_ca));
        check("R3", "ca32", 64'(ca32_o), 64'(e_ca));
        // R10
        check("R10", "op_pass", 64'(op_o), 64'(op[2:0]));
        check("R10", "tag_pass", 64'(tag_o), 64'(tag));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 idle state with code 0
        check("R9", "idle_result", result_o, 64'd0);
        check("R9", "idle_valid", 64'(valid_o), 64'd0);

        // R1 boundaries
        apply(1, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 7'd64, 0, 0, 1);
        apply(1, 0, 0, 64'h0000_0000_0000_0001, 0, 7'd63, 0, 0, 2);
        apply(1, 1, 0, 64'h1234_5678_9ABC_DEF1, 0, 7'd4, 0, 0, 3);
        apply(1, 1, 0, 64'h1234_5678_9ABC_DEF1, 0, 7'd32, 0, 0, 0);
        // R2 and R3: negative with and without lost bits, huge amounts
        apply(2, 0, 1, 64'h8000_0000_0000_0010, 0, 7'd4, 0, 0, 1);
        apply(2, 0, 1, 64'h8000_0000_0000_0010, 0, 7'd5, 0, 0, 1);
        apply(2, 0, 1, 64'h8000_0000_0000_0000, 0, 7'd127, 0, 0, 2);
        apply(2, 1, 1, 64'h0000_0000_8000_0001, 0, 7'd1, 0, 0, 2);
        apply(2, 1, 0, 64'hFFFF_FFFF_8000_0001, 0, 7'd1, 0, 0, 3);
        apply(2, 0, 1, 64'h7FFF_FFFF_FFFF_FFFF, 0, 7'd3, 0, 0, 3);
        // R5 and R7: plain and wrapped word masks with insert
        apply(3, 1, 0, 64'hDEAD_BEEF_0123_4567, 64'hAAAA_AAAA_5555_5555,
              7'd8, 6'd4, 5'd27, 1);
        apply(3, 1, 0, 64'hDEAD_BEEF_0123_4567, 64'hAAAA_AAAA_5555_5555,
              7'd13, 6'd28, 5'd3, 2);
        // R6: rotated mask-begin field, end tied to amount
        apply(4, 0, 0, 64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000,
              7'd12, 6'b000001, 0, 3);
        apply(4, 0, 0, 64'h0123_4567_89AB_CDEF, 64'h0F0F_0F0F_0F0F_0F0F,
              7'd0, 6'b101010, 0, 0);
        // R8: negative word, mode flag ignored
        apply(5, 1, 0, 64'h0000_0000_8000_0003, 0, 7'd2, 0, 0, 1);
        apply(5, 0, 1, 64'hFFFF_0000_7000_0000, 0, 7'd63, 0, 0, 2);
        // R9: undefined codes
        apply(6, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 7'd1, 0, 0, 3);
        apply(7, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 7'd1, 0, 0, 1);
        apply(0, 0, 1, 64'h8000_0000_0000_0001, 64'h1, 7'd1, 0, 0, 2);

        for (int n = 0; n < 4000; n++) begin
            logic [63:0] rs = {$urandom, $urandom};
            logic [63:0] ra = {$urandom, $urandom};
            int r = $urandom;
            apply(int'(r[2:0]), r[3], r[4], rs, ra, 7'(r >> 5), 6'(r >> 12),
                  5'(r >> 18), TAG_W'(r >> 23));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule